// File: doc/BRIEF.md
# Serial Port Flag and Interrupt Register Block

This block is the firmware-facing register set of a serial port. It keeps three status flags: transmit register free, transmission finished and received character waiting. It also holds a received-character register, a stored baud divisor and a control register with per-flag interrupt enables. From these it drives one level-sensitive interrupt line. Firmware reaches the registers over a plain synchronous bus. The bus has an address, a write strobe with write data, and a read strobe whose data comes back one cycle later.

A receive strobe from the line side delivers each incoming character. A write to the data register hands the low bits to the transmit side as a one-cycle strobe. The transmit side is taken to finish at once, so the transmit-free flag stays set. Every bus access, received character and reset leads to a fresh interrupt decision. The line therefore always matches the present flags and enables one cycle after the event that changed them.

Top module: `uart_flag_irq_ctrl`

## Requirements
- R1: After reset the status register (offset 0x0) reads 0xC0, with transmit-free in bit 7, finished in bit 6 and receive-waiting in bit 5 clear. Control (0xC) and baud (0x8) read zero and irq_o is low.
- R2: From the cycle after any event, irq_o is high exactly when some flag in bits 7, 6 or 5 of status is set and the control bit at the same position is set.
- R3: Writing an enable for a flag that is already set raises irq_o in the cycle right after the write.
- R4: A receive strobe stores the full received word and sets receive-waiting. A second strobe before the data is read replaces the stored word, and the flag stays set.
- R5: A read of the data register (0x4) returns the stored word masked to its low 10 bits and clears receive-waiting. A receive strobe in the same cycle wins: the flag stays set, the new word is stored, and the read returns the old word.
- R6: A status write can only clear flags. Each flag becomes its old value ANDed with the written bit at its position.
- R7: A data write sets the finished flag and leaves transmit-free unchanged. In the following cycle it gives a one-cycle tx_valid_o carrying the low 9 bits of the written word.
- R8: Offsets 0x0, 0x4, 0x8 and 0xC are decoded; any other offset reads zero. Read data appears the cycle after the read strobe and is zero when no read was made.
- R9: Control bits outside 7..5, such as the unit enable in bit 13 and the transmitter and receiver enables in bits 3 and 2, are stored but never affect irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | 4 | Register byte offset |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after bus_re_i |
| rx_valid_i | input | 1 | Received-character strobe |
| rx_data_i | input | 16 | Received character |
| tx_valid_o | output | 1 | One-cycle transmit strobe |
| tx_data_o | output | 9 | Character to transmit |
| irq_o | output | 1 | Level interrupt |

## Verification
The interrupt line is registered from the next-state flags and enables. A flag that is stuck or missed therefore shows on irq_o one cycle after the triggering access, provided its enable is set. The same fault shows in the status read data that returns the following cycle. A wrong clear on a data read, or a lost overwrite, shows directly in the next status or data readback. A missing finished re-arm shows at once on irq_o when that flag's enable is set.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;

    // register offsets (byte addresses)
    localparam int unsigned OFF_STATUS = 0;
    localparam int unsigned OFF_DATA   = 4;
    localparam int unsigned OFF_BAUD   = 8;
    localparam int unsigned OFF_CTRL   = 12;

    // flag positions in status and matching enables in control
    localparam int unsigned POS_RXW  = 5;   // receive waiting
    localparam int unsigned POS_FIN  = 6;   // transmission finished
    localparam int unsigned POS_FREE = 7;   // transmit register free

    localparam int unsigned NUM_FLAGS = 3;  // flag index 0 = POS_RXW upward

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_DATA,
        SEL_BAUD,
        SEL_CTRL
    } reg_sel_e;

endpackage

// File: rtl/flag_irq_eval.sv
module flag_irq_eval #(
    parameter int unsigned NUM_SRC = 3,
    parameter int unsigned BASE    = 5,
    parameter int unsigned CTRL_W  = 16
) (
    input  logic [NUM_SRC-1:0] flags_i,
    input  logic [CTRL_W-1:0]  ctrl_i,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign hit[g] = flags_i[g] & ctrl_i[BASE + g];
    end

    assign irq_o = |hit;
endmodule

// File: rtl/reg_read_mux.sv
module reg_read_mux
    import uart_flag_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned RX_W     = 16,
    parameter int unsigned RD_W     = 10,
    parameter int unsigned BAUD_W   = 16,
    parameter int unsigned CTRL_W   = 16,
    parameter int unsigned NUM_SRC  = 3,
    parameter int unsigned BASE     = 5
) (
    input  reg_sel_e            sel_i,
    input  logic [NUM_SRC-1:0]  flags_i,
    input  logic [RX_W-1:0]     rx_word_i,
    input  logic [BAUD_W-1:0]   baud_i,
    input  logic [CTRL_W-1:0]   ctrl_i,
    output logic [DATA_W-1:0]   value_o
);
    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] data_word;

    always_comb begin
        status_word = '0;
        status_word[BASE +: NUM_SRC] = flags_i;
        data_word = '0;
        data_word[RD_W-1:0] = rx_word_i[RD_W-1:0];
    end

    always_comb begin
        unique case (sel_i)
            SEL_STATUS: value_o = status_word;
            SEL_DATA:   value_o = data_word;
            SEL_BAUD:   value_o = DATA_W'(baud_i);
            SEL_CTRL:   value_o = DATA_W'(ctrl_i);
            default:    value_o = '0;
        endcase
    end
endmodule

// File: rtl/uart_flag_irq_ctrl.sv
module uart_flag_irq_ctrl
    import uart_flag_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned RX_W   = 16,
    parameter int unsigned RD_W   = 10,
    parameter int unsigned TX_W   = 9,
    parameter int unsigned BAUD_W = 16,
    parameter int unsigned CTRL_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic              bus_re_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              rx_valid_i,
    input  logic [RX_W-1:0]   rx_data_i,
    output logic              tx_valid_o,
    output logic [TX_W-1:0]   tx_data_o,
    output logic              irq_o
);
    localparam int unsigned NF       = NUM_FLAGS;
    localparam int unsigned IDX_RXW  = POS_RXW  - POS_RXW;
    localparam int unsigned IDX_FIN  = POS_FIN  - POS_RXW;
    localparam int unsigned IDX_FREE = POS_FREE - POS_RXW;
    localparam logic [NF-1:0] FLAGS_RST = NF'((1 << IDX_FREE) | (1 << IDX_FIN));

    typedef struct packed {
        logic [NF-1:0]     flags;
        logic [RX_W-1:0]   rx_word;
        logic [BAUD_W-1:0] baud;
        logic [CTRL_W-1:0] ctrl;
        logic [DATA_W-1:0] rdata;
        logic              tx_valid;
        logic [TX_W-1:0]   tx_data;
    } state_t;

    state_t   st_d, st_q;
    logic     irq_d, irq_q;
    reg_sel_e sel;
    logic [DATA_W-1:0] rd_value;

    // address decode
    always_comb begin
        if (bus_addr_i == ADDR_W'(OFF_STATUS))     sel = SEL_STATUS;
        else if (bus_addr_i == ADDR_W'(OFF_DATA))  sel = SEL_DATA;
        else if (bus_addr_i == ADDR_W'(OFF_BAUD))  sel = SEL_BAUD;
        else if (bus_addr_i == ADDR_W'(OFF_CTRL))  sel = SEL_CTRL;
        else                                       sel = SEL_NONE;
    end

    reg_read_mux #(
        .DATA_W (DATA_W),
        .RX_W   (RX_W),
        .RD_W   (RD_W),
        .BAUD_W (BAUD_W),
        .CTRL_W (CTRL_W),
        .NUM_SRC(NF),
        .BASE   (POS_RXW)
    ) rd_mux_i (
        .sel_i    (sel),
        .flags_i  (st_q.flags),
        .rx_word_i(st_q.rx_word),
        .baud_i   (st_q.baud),
        .ctrl_i   (st_q.ctrl),
        .value_o  (rd_value)
    );

    // next state
    always_comb begin
        st_d          = st_q;
        st_d.tx_valid = 1'b0;
        st_d.rdata    = bus_re_i ? rd_value : '0;

        if (bus_we_i) begin
            unique case (sel)
                SEL_STATUS: st_d.flags = st_q.flags & bus_wdata_i[POS_RXW +: NF];
                SEL_DATA: begin
                    st_d.flags[IDX_FIN] = 1'b1;
                    st_d.tx_valid       = 1'b1;
                    st_d.tx_data        = bus_wdata_i[TX_W-1:0];
                end
                SEL_BAUD: st_d.baud = bus_wdata_i[BAUD_W-1:0];
                SEL_CTRL: st_d.ctrl = bus_wdata_i[CTRL_W-1:0];
                default: ;
            endcase
        end

        if (bus_re_i && sel == SEL_DATA) begin
            st_d.flags[IDX_RXW] = 1'b0;
        end

        // a character arriving this cycle has the last word
        if (rx_valid_i) begin
            st_d.rx_word        = rx_data_i;
            st_d.flags[IDX_RXW] = 1'b1;
        end
    end

    flag_irq_eval #(
        .NUM_SRC(NF),
        .BASE   (POS_RXW),
        .CTRL_W (CTRL_W)
    ) irq_eval_i (
        .flags_i(st_d.flags),
        .ctrl_i (st_d.ctrl),
        .irq_o  (irq_d)
    );

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q       <= '0;
            st_q.flags <= FLAGS_RST;
            irq_q      <= 1'b0;
        end else begin
            st_q  <= st_d;
            irq_q <= irq_d;
        end
    end

    assign bus_rdata_o = st_q.rdata;
    assign tx_valid_o  = st_q.tx_valid;
    assign tx_data_o   = st_q.tx_data;
    assign irq_o       = irq_q;

    // views for the bound checker
    logic              free_w, fin_w, rxw_w;
    logic [CTRL_W-1:0] ctrl_w;
    assign free_w = st_q.flags[IDX_FREE];
    assign fin_w  = st_q.flags[IDX_FIN];
    assign rxw_w  = st_q.flags[IDX_RXW];
    assign ctrl_w = st_q.ctrl;
endmodule

module uart_flag_irq_ctrl_chk
    import uart_flag_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned CTRL_W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              bus_we_i,
    input logic              bus_re_i,
    input logic              rx_valid_i,
    input logic              tx_valid_o,
    input logic              irq_o,
    input logic              free_w,
    input logic              fin_w,
    input logic              rxw_w,
    input logic [CTRL_W-1:0] ctrl_w
);
    logic at_data, at_status;
    assign at_data   = bus_addr_i == ADDR_W'(OFF_DATA);
    assign at_status = bus_addr_i == ADDR_W'(OFF_STATUS);

    AST_IRQ_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == ((free_w & ctrl_w[POS_FREE]) | (fin_w & ctrl_w[POS_FIN]) | (rxw_w & ctrl_w[POS_RXW]))); // R2
    AST_RX_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_valid_i |=> rxw_w); // R4
    AST_DATA_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_re_i && at_data && !rx_valid_i) |=> !rxw_w); // R5
    AST_STATUS_ONLY_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && at_status) |=> (!free_w || $past(free_w)) && (!fin_w || $past(fin_w))); // R6
    AST_DATA_WRITE_SENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && at_data) |=> (tx_valid_o && fin_w && free_w == $past(free_w))); // R7
    AST_TX_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_we_i && at_data) |=> !tx_valid_o); // R7
endmodule

bind uart_flag_irq_ctrl uart_flag_irq_ctrl_chk #(
    .ADDR_W(ADDR_W),
    .CTRL_W(CTRL_W)
) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bus_addr_i(bus_addr_i),
    .bus_we_i  (bus_we_i),
    .bus_re_i  (bus_re_i),
    .rx_valid_i(rx_valid_i),
    .tx_valid_o(tx_valid_o),
    .irq_o     (irq_o),
    .free_w    (free_w),
    .fin_w     (fin_w),
    .rxw_w     (rxw_w),
    .ctrl_w    (ctrl_w)
);

// File: tb/uart_flag_irq_ctrl_tb.sv
module uart_flag_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rx_valid = 1'b0;
    logic [15:0] rx_data = '0;
    logic        tx_valid;
    logic [8:0]  tx_data;
    logic        irq;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    uart_flag_irq_ctrl dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .bus_addr_i (addr),
        .bus_we_i   (we),
        .bus_re_i   (re),
        .bus_wdata_i(wdata),
        .bus_rdata_o(rdata),
        .rx_valid_i (rx_valid),
        .rx_data_i  (rx_data),
        .tx_valid_o (tx_valid),
        .tx_data_o  (tx_data),
        .irq_o      (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // each task starts and ends at a falling edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a; re = 1'b1;
        @(negedge clk);
        re = 1'b0;
        d = rdata;
    endtask

    task automatic rx(input logic [15:0] c);
        rx_data = c; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq", {31'b0, irq}, 32'h0);
        rd(4'h0, v); check("R1 status", v, 32'hC0);
        rd(4'hC, v); check("R1 ctrl", v, 32'h0);
        rd(4'h8, v); check("R1 baud", v, 32'h0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(4'h8, 32'hFFFF_1234);
        rd(4'h8, v); check("R8 baud", v, 32'h1234);
        rd(4'h2, v); check("R8 unmapped", v, 32'h0);
        @(negedge clk);
        check("R8 idle rdata", rdata, 32'h0);
    endtask

    task automatic t_enables();
        logic [31:0] v;
        wr(4'hC, 32'h0000_200C);
        check("R9 other ctrl bits", {31'b0, irq}, 32'h0);
        rd(4'hC, v); check("R8 ctrl readback", v, 32'h200C);
        wr(4'hC, 32'h0000_0080);
        check("R3 enable pending free", {31'b0, irq}, 32'h1);
        wr(4'hC, 32'h0000_0040);
        check("R3 enable pending fin", {31'b0, irq}, 32'h1);
        wr(4'h0, 32'hFFFF_FFBF);
        check("R2 fin cleared", {31'b0, irq}, 32'h0);
        rd(4'h0, v); check("R6 status and", v, 32'h80);
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, v); check("R6 no set", v, 32'h80);
    endtask

    task automatic t_tx();
        logic [31:0] v;
        addr = 4'h4; wdata = 32'h0000_F3A5; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        check("R7 tx strobe", {31'b0, tx_valid}, 32'h1);
        check("R7 tx data", {23'b0, tx_data}, 32'h1A5);
        check("R7 fin rearm irq", {31'b0, irq}, 32'h1);
        @(negedge clk);
        check("R7 strobe one cycle", {31'b0, tx_valid}, 32'h0);
        rd(4'h0, v); check("R7 status after send", v, 32'hC0);
    endtask

    task automatic t_rx();
        logic [31:0] v;
        wr(4'hC, 32'h0000_0020);
        check("R2 only rx enabled", {31'b0, irq}, 32'h0);
        rx(16'hFFFF);
        check("R4 irq on rx", {31'b0, irq}, 32'h1);
        rd(4'h0, v); check("R4 status", v, 32'hE0);
        rx(16'h0F3C);
        rd(4'h4, v); check("R5 masked overwrite", v, 32'h33C);
        check("R5 irq drops", {31'b0, irq}, 32'h0);
        rd(4'h0, v); check("R5 flag clear", v, 32'hC0);
        rx(16'h0011);
        // read and new arrival in one cycle
        addr = 4'h4; re = 1'b1; rx_data = 16'h0222; rx_valid = 1'b1;
        @(negedge clk);
        re = 1'b0; rx_valid = 1'b0;
        check("R5 collide old data", rdata, 32'h11);
        check("R5 collide irq", {31'b0, irq}, 32'h1);
        rd(4'h4, v); check("R5 collide new data", v, 32'h222);
        rx(16'h0055);
        wr(4'h0, 32'hFFFF_FFDF);
        check("R6 rx cleared by write", {31'b0, irq}, 32'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_enables();
        t_tx();
        t_rx();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule